// File: doc/BRIEF.md
# Serial Keypad Report Shifter

This block is the device end of a three-wire keypad link. The three wires are a latch strobe, a shift clock and a serial data line. While the host holds the latch strobe high, the block keeps loading a snapshot of every switch into a chain of 8-bit shift stages. The snapshot freezes when the strobe drops. From then on, each rising edge of the shift clock moves the report along by one bit, starting at bit 0. Ones enter the far end of the chain, so a host that keeps clocking after the report ends reads 1.

The report layout is fixed by position:

- Bit 0 carries the P/T mode switch, which reads 1 in the T position.
- Bits 3 and 11 are always 1.
- Every other position carries the key wired to that index. Key inputs are active-low at the pins, and a pressed key is reported as 1.
- The parameter `EXTENDED` selects the report size. With `EXTENDED=0` the report is 24 bits from three stages. With `EXTENDED=1` it is 32 bits from four stages, and bits 24..31 carry eight extra keys.

Latch and shift-clock are sampled on the block clock `clk`, and the shift-clock edge is detected in that domain. Both inputs are assumed to be already synchronous to `clk`.

Top module: `keypad_report_shifter`

## Requirements
- R1: While `rst_n` is low at a `clk` edge, every chain bit is set to 1, so `data_o` reads 1 and a read without a latch yields only ones.
- R2: Each `clk` edge with `latch_i` high loads the snapshot. One edge later, `data_o` equals `pt_mode_i` (1 = T position).
- R3: Report bits 3 and 11 read 1 whatever `keys_n_i[3]` and `keys_n_i[11]` are. `keys_n_i[0]` is ignored too, because bit 0 comes from `pt_mode_i`.
- R4: For every other index i below the report width, report bit i is the inverse of `keys_n_i[i]`, so 0 at the pin means pressed and is reported as 1.
- R5: While `latch_i` is low, each 0-to-1 change of `sclk_i` seen at a `clk` edge advances `data_o` to the next report bit, in ascending index order.
- R6: After the last report bit has been shifted out, `data_o` stays 1 for any number of further shift edges.
- R7: With `EXTENDED=0` the report is 24 bits, and index 24 onward reads 1. With `EXTENDED=1` it is 32 bits, and indices 24..31 report keys.
- R8: Any combination of pressed keys is reported, with no interaction between positions.
- R9: Holding `sclk_i` high over many `clk` edges advances the report only once.
- R10: After `latch_i` falls, changes on `keys_n_i` and `pt_mode_i` do not alter the report being shifted out.
- R11: While `latch_i` is high, a rising `sclk_i` does not shift; the load wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| latch_i | input | 1 | Latch strobe; high loads the live snapshot |
| sclk_i | input | 1 | Shift clock; each rising edge advances one bit |
| pt_mode_i | input | 1 | P/T mode switch, 1 = T position |
| keys_n_i | input | 24 or 32 (REPORT_W) | Active-low key inputs indexed by report position |
| data_o | output | 1 | Serial report bit |

## Verification
The bench uses two instances side by side: one base and one extended. Each is fed seeded random key patterns, together with directed all-pressed, none-pressed and alternating patterns. Each full read runs well past the report end, which separates the 24-bit and 32-bit lengths and checks the ones that fill in behind the report. Flipping the inputs that feed the fixed positions, and changing keys after the latch falls, separates real position decoding from pass-through. Latch pulses that overlap a shift-clock pulse, and shift-clock pulses held high for several cycles, separate edge detection from level sensing.

// File: rtl/keypad_pkg.sv
// Package: shared constants and position decoding for the keypad report.
// Assumes the report is made of whole 8-bit stages.
package keypad_pkg;

    localparam int STAGE_W      = 8;
    localparam int BASE_STAGES  = 3;
    localparam int EXT_STAGES   = 4;
    localparam int MODE_BIT     = 0;
    localparam int FIXED_A_BIT  = 3;
    localparam int FIXED_B_BIT  = 11;

    // True for report positions that are hard-wired to 1.
    function automatic logic is_fixed_one(input int idx);
        return (idx == FIXED_A_BIT) || (idx == FIXED_B_BIT);
    endfunction

endpackage

// File: rtl/keypad_edge_detect.sv
// Module: detects a 0-to-1 change on a level that is sampled on clk.
// Assumes sig_i is already synchronous to clk.
module keypad_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);

    logic sig_q;

    // Remember last cycle's level of the sampled signal.
    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig_i;
    end

    assign rise_o = sig_i && !sig_q;

endmodule

// File: rtl/keypad_shift_stage.sv
// Module: one parallel-load, right-shifting stage of the report chain.
// Assumes load has priority over shift; reset fills the stage with ones.
module keypad_shift_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         shift_i,
    input  logic [W-1:0] par_i,
    input  logic         ser_i,
    output logic [W-1:0] q_o
);

    // Load the snapshot, shift toward bit 0, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       q_o <= '1;
        else if (load_i)  q_o <= par_i;
        else if (shift_i) q_o <= {ser_i, q_o[W-1:1]};
    end

    // R5: after a shift the top bit holds the incoming serial bit.
    p_stage_shift_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !load_i) |=> (q_o[W-1] == $past(ser_i)));

    // R10: without load or shift the stage holds its contents.
    p_stage_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_i && !load_i) |=> $stable(q_o));

endmodule

// File: rtl/keypad_report_shifter.sv
// Module: latch/clock/data keypad report shifter. Builds the report
// snapshot, chains the shift stages and drives the serial data line.
// Assumes latch_i and sclk_i are synchronous to clk.
module keypad_report_shifter #(
    parameter bit EXTENDED = 1'b0,
    localparam int STAGES   = EXTENDED ? keypad_pkg::EXT_STAGES : keypad_pkg::BASE_STAGES,
    localparam int REPORT_W = STAGES * keypad_pkg::STAGE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                latch_i,
    input  logic                sclk_i,
    input  logic                pt_mode_i,
    input  logic [REPORT_W-1:0] keys_n_i,
    output logic                data_o
);
    import keypad_pkg::*;

    logic [REPORT_W-1:0] snap;
    logic [REPORT_W-1:0] chain_q;
    logic                sclk_rise;
    logic                shift_en;
    logic                unused_inputs;

    // Positions fed by the mode switch or by a constant ignore their key pin.
    assign unused_inputs = keys_n_i[MODE_BIT] ^ keys_n_i[FIXED_A_BIT] ^ keys_n_i[FIXED_B_BIT];

    // Build the snapshot position by position.
    for (genvar i = 0; i < REPORT_W; i++) begin : g_snap
        if (i == MODE_BIT) begin : g_mode
            assign snap[i] = pt_mode_i;
        end else if (is_fixed_one(i)) begin : g_fixed
            assign snap[i] = 1'b1;
        end else begin : g_key
            assign snap[i] = ~keys_n_i[i];
        end
    end

    keypad_edge_detect u_sclk_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (sclk_i),
        .rise_o (sclk_rise)
    );

    assign shift_en = sclk_rise && !latch_i;

    // Chain the stages; the last stage takes in ones.
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic ser_in;
        if (s == STAGES - 1) begin : g_tail
            assign ser_in = 1'b1;
        end else begin : g_link
            assign ser_in = chain_q[(s + 1) * STAGE_W];
        end
        keypad_shift_stage #(.W(STAGE_W)) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_i  (latch_i),
            .shift_i (shift_en),
            .par_i   (snap[s * STAGE_W +: STAGE_W]),
            .ser_i   (ser_in),
            .q_o     (chain_q[s * STAGE_W +: STAGE_W])
        );
    end

    assign data_o = chain_q[0];

    // R2: one edge after a latch cycle the line shows the mode switch.
    p_mode_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        latch_i |=> (data_o == $past(pt_mode_i)));

    // R3: fixed positions hold 1 after every load.
    p_fixed_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
        latch_i |=> (chain_q[FIXED_A_BIT] && chain_q[FIXED_B_BIT]));

    // R6: a shift always leaves a 1 at the far end of the chain.
    p_fill_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise && !latch_i) |=> chain_q[REPORT_W-1]);

    // R11: a latch cycle never shifts, even with a clock edge present.
    p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_i && sclk_rise) |=> (chain_q == $past(snap)));

    // R1: immediate check that reset leaves the line high.
    always_ff @(posedge clk) begin
        if (rst_n && $past(!rst_n)) begin
            a_reset_high_r1: assert (data_o == 1'b1);
        end
    end

endmodule

// File: tb/keypad_report_shifter_bench.sv
`timescale 1ns/1ps
module keypad_report_shifter_bench;

    localparam int READ_LEN = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        latch = 1'b0;
    logic        sclk = 1'b0;
    logic        pt = 1'b0;
    logic [31:0] keys_n = '1;
    logic        dout_base;
    logic        dout_ext;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    keypad_report_shifter #(.EXTENDED(1'b0)) u_keypad_report_shifter (
        .clk (clk), .rst_n (rst_n), .latch_i (latch), .sclk_i (sclk),
        .pt_mode_i (pt), .keys_n_i (keys_n[23:0]), .data_o (dout_base)
    );

    keypad_report_shifter #(.EXTENDED(1'b1)) u_keypad_report_shifter_ext (
        .clk (clk), .rst_n (rst_n), .latch_i (latch), .sclk_i (sclk),
        .pt_mode_i (pt), .keys_n_i (keys_n), .data_o (dout_ext)
    );

    // Expected report bit from the requirements.
    function automatic logic exp_bit(input bit ext, input logic p,
                                     input logic [31:0] kn, input int idx);
        int width = ext ? 32 : 24;
        if (idx >= width)           return 1'b1;            // R6, R7
        if (idx == 0)               return p;               // R2
        if (idx == 3 || idx == 11)  return 1'b1;            // R3
        return ~kn[idx];                                     // R4, R8
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Latch a pattern, with a shift-clock pulse overlapping the latch (R11).
    task automatic do_latch(input logic p, input logic [31:0] kn);
        @(negedge clk);
        latch = 1'b1; pt = p; keys_n = kn; sclk = 1'b1;
        @(negedge clk);
        sclk = 1'b0;
        @(negedge clk);
        check("R2/R11 base mode bit", dout_base, p);
        check("R2/R11 ext mode bit", dout_ext, p);
        latch = 1'b0;
        @(negedge clk);
    endtask

    // Shift out READ_LEN bits and compare both instances.
    task automatic do_read(input logic p, input logic [31:0] kn,
                           input bit all_ones, input int hold);
        // R10: scramble the live inputs after the latch fell.
        pt = ~p; keys_n = ~kn;
        for (int idx = 0; idx < READ_LEN; idx++) begin
            check($sformatf("R5 base bit %0d", idx), dout_base,
                  all_ones ? 1'b1 : exp_bit(1'b0, p, kn, idx));
            check($sformatf("R5 ext bit %0d", idx), dout_ext,
                  all_ones ? 1'b1 : exp_bit(1'b1, p, kn, idx));
            sclk = 1'b1;
            // R9: a held-high clock shifts only once.
            for (int h = 0; h <= hold; h++) @(negedge clk);
            sclk = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        logic [31:0] kn;
        logic        p;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 base reset", dout_base, 1'b1);
        check("R1 ext reset", dout_ext, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        do_read(1'b0, 32'h0, 1'b1, 0);                     // R1 all ones

        do_latch(1'b1, 32'h0);                              // R8 all pressed
        do_read(1'b1, 32'h0, 1'b0, 0);
        do_latch(1'b0, 32'hFFFF_FFFF);                      // none pressed
        do_read(1'b0, 32'hFFFF_FFFF, 1'b0, 2);
        do_latch(1'b1, 32'hFFFF_F7F6);                      // R3 fixed pins low
        do_read(1'b1, 32'hFFFF_F7F6, 1'b0, 0);
        do_latch(1'b0, 32'hAAAA_5555);                      // alternating
        do_read(1'b0, 32'hAAAA_5555, 1'b0, 3);

        for (int t = 0; t < 30; t++) begin
            kn = $urandom;
            p  = 1'($urandom);
            do_latch(p, kn);
            do_read(p, kn, 1'b0, int'($urandom_range(0, 2)));
        end

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule